// File: doc/BRIEF.md
# Subcode Q Block Checker and Serial Reader

This block sits behind the disc data demodulator and watches the eight-bit subcode symbol delivered once per frame. From each symbol it keeps only the Q-channel bit. Across one 98-frame subcode block it drops the two leading sync frames and gathers 96 Q bits: an 80-bit payload followed by a 16-bit check field. It then runs a CRC-16 check over the payload.

Only a block whose check passes is placed in a holding register and announced to the host through a ready flag. The host then pulls the 80 payload bits out one at a time, least significant first. Each bit advances on a rising edge of a read clock that the host supplies. That clock is synchronised into the block's clock domain.

A host read in progress is never disturbed. A newer valid block that arrives during the read is parked and offered as soon as the 80th bit has been clocked out.

Top module: `subq_reader`

## Requirements
- R1: After synchronous reset, q_ready is 0 and q_sdo is 0.
- R2: Only bit 6 of sym_data (the Q bit) is used. The other seven symbol bits have no effect on the payload or on the check result.
- R3: The strobe that carries blk_sync is frame 0 of a block. Frames 0 and 1 are skipped. The Q bit of frame k+2 becomes payload bit k, for k from 0 to 79. Frames 82 to 97 carry the check field, first-arriving bit most significant.
- R4: The check uses a register cleared to zero, fed with the 80 payload bits in arrival order, most significant register bit out first, with polynomial x^16+x^12+x^5+1 (0x1021). A block passes when its check field equals the bitwise inverse of the final register. On a pass, q_ready is 1 within two clock cycles after the strobe of frame 97.
- R5: A block that fails the check never raises q_ready. It also clears a q_ready that is still set from an earlier block.
- R6: While q_ready is 1, q_sdo shows payload bit 0. After the k-th rising edge of rd_clk it shows bit k, within three clock cycles of that edge.
- R7: The first rd_clk rising edge of a read clears q_ready. Rising edges of rd_clk while no block is offered and no read is running leave q_sdo and q_ready unchanged.
- R8: During a read, the holding register is not loaded. A valid block completed during the read is offered, with q_ready set, right after the 80th rising edge.
- R9: Strobes without blk_sync are ignored when no block is open. A blk_sync in the middle of a block abandons that block and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | One-cycle strobe per frame carrying a subcode symbol |
| sym_data | input | 8 | Subcode symbol; bit 6 is the Q bit |
| blk_sync | input | 1 | Qualifies a strobe as frame 0 of a subcode block |
| rd_clk | input | 1 | Host read clock, asynchronous; rising edge advances one bit |
| q_sdo | output | 1 | Serial payload bit, least significant first |
| q_ready | output | 1 | A checked payload is waiting to be read |

## Verification
If the frame counter slips, the payload appears shifted or the check fails. Either shows up at the ports on the next block: q_ready stays low, or the serial bits differ from the expected payload starting at the first wrong position. A wrong check register or wrong check-field order drops every good block, so q_ready is missing two cycles after frame 97. A readout state that forgets a read is in progress lets q_sdo change under the host mid-read. A lost parked block leaves q_ready low after the 80th edge, and this is seen on the following edge or at the next ready sample.

// File: rtl/subq_pkg.sv
package subq_pkg;

    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef logic [CRC_W-1:0] crc_t;

    // result of one completed subcode block
    typedef struct packed {
        logic done;
        logic ok;
    } blk_res_t;

    // one serial step of the check register, register MSB leaves first
    function automatic crc_t crc_step(crc_t c, logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/subq_assembler.sv
module subq_assembler
    import subq_pkg::*;
#(
    parameter int SYNC_FRAMES = 2,
    parameter int DATA_BITS   = 80
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sym_valid,
    input  logic                 qbit,
    input  logic                 blk_sync,
    output blk_res_t             res,
    output logic [DATA_BITS-1:0] payload
);
    localparam int FRAMES = SYNC_FRAMES + DATA_BITS + CRC_W;
    localparam int FCW    = $clog2(FRAMES + 1);
    localparam logic [FCW-1:0] IDLE    = FCW'(FRAMES);
    localparam logic [FCW-1:0] FIRST_D = FCW'(SYNC_FRAMES);
    localparam logic [FCW-1:0] FIRST_C = FCW'(SYNC_FRAMES + DATA_BITS);
    localparam logic [FCW-1:0] LAST    = FCW'(FRAMES - 1);

    logic [FCW-1:0] fcnt;
    crc_t           crc;
    crc_t           chk;
    crc_t           chk_n;

    assign chk_n = {chk[CRC_W-2:0], qbit};

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt    <= IDLE;
            crc     <= '0;
            chk     <= '0;
            payload <= '0;
            res     <= '0;
        end else begin
            res <= '0;
            if (sym_valid) begin
                if (blk_sync) begin
                    fcnt <= FCW'(1);
                    crc  <= '0;
                end else if (fcnt != IDLE) begin
                    fcnt <= fcnt + FCW'(1);
                    if (fcnt >= FIRST_C) begin
                        chk <= chk_n;
                        if (fcnt == LAST) begin
                            res.done <= 1'b1;
                            res.ok   <= (chk_n == ~crc);
                        end
                    end else if (fcnt >= FIRST_D) begin
                        payload <= {qbit, payload[DATA_BITS-1:1]};
                        crc     <= crc_step(crc, qbit);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/subq_rdsync.sv
module subq_rdsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_clk,
    output logic rd_rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], rd_clk};
    end

    assign rd_rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/subq_readout.sv
module subq_readout
    import subq_pkg::*;
#(
    parameter int DATA_BITS = 80
) (
    input  logic                 clk,
    input  logic                 rst,
    input  blk_res_t             res,
    input  logic [DATA_BITS-1:0] payload,
    input  logic                 rd_rise,
    output logic                 sdo,
    output logic                 ready,
    output logic                 busy
);
    localparam int CW = $clog2(DATA_BITS + 1);

    logic [DATA_BITS-1:0] sh, sh_n, pend, pend_n;
    logic                 pend_vld, pend_vld_n, ready_n, busy_n;
    logic [CW-1:0]        bcnt, bcnt_n;

    always_comb begin
        sh_n       = sh;
        pend_n     = pend;
        pend_vld_n = pend_vld;
        ready_n    = ready;
        busy_n     = busy;
        bcnt_n     = bcnt;
        if (rd_rise) begin
            if (busy) begin
                sh_n   = sh >> 1;
                bcnt_n = bcnt + CW'(1);
                if (bcnt == CW'(DATA_BITS - 1)) begin
                    busy_n = 1'b0;
                    if (pend_vld) begin
                        sh_n       = pend;
                        ready_n    = 1'b1;
                        pend_vld_n = 1'b0;
                    end
                end
            end else if (ready) begin
                ready_n = 1'b0;
                busy_n  = 1'b1;
                sh_n    = sh >> 1;
                bcnt_n  = CW'(1);
            end
        end
        if (res.done) begin
            if (!res.ok) begin
                ready_n    = 1'b0;
                pend_vld_n = 1'b0;
            end else if (busy_n) begin
                pend_n     = payload;
                pend_vld_n = 1'b1;
            end else begin
                sh_n    = payload;
                ready_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            pend     <= '0;
            pend_vld <= 1'b0;
            ready    <= 1'b0;
            busy     <= 1'b0;
            bcnt     <= '0;
        end else begin
            sh       <= sh_n;
            pend     <= pend_n;
            pend_vld <= pend_vld_n;
            ready    <= ready_n;
            busy     <= busy_n;
            bcnt     <= bcnt_n;
        end
    end

    assign sdo = sh[0];

endmodule

// File: rtl/subq_reader.sv
module subq_reader
    import subq_pkg::*;
#(
    parameter int SYM_W       = 8,
    parameter int Q_POS       = 6,
    parameter int SYNC_FRAMES = 2,
    parameter int DATA_BITS   = 80,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             blk_sync,
    input  logic             rd_clk,
    output logic             q_sdo,
    output logic             q_ready
);
    blk_res_t             res;
    logic [DATA_BITS-1:0] payload;
    logic                 rd_rise;
    logic                 busy;
    logic                 blk_done;
    logic                 blk_ok;
    logic                 sym_unused;

    assign sym_unused = ^sym_data;
    assign blk_done   = res.done;
    assign blk_ok     = res.ok;

    subq_assembler #(
        .SYNC_FRAMES(SYNC_FRAMES),
        .DATA_BITS  (DATA_BITS)
    ) u_asm (
        .clk      (clk),
        .rst      (rst),
        .sym_valid(sym_valid),
        .qbit     (sym_data[Q_POS]),
        .blk_sync (blk_sync),
        .res      (res),
        .payload  (payload)
    );

    subq_rdsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .rd_clk (rd_clk),
        .rd_rise(rd_rise)
    );

    subq_readout #(.DATA_BITS(DATA_BITS)) u_out (
        .clk    (clk),
        .rst    (rst),
        .res    (res),
        .payload(payload),
        .rd_rise(rd_rise),
        .sdo    (q_sdo),
        .ready  (q_ready),
        .busy   (busy)
    );

endmodule

// File: rtl/subq_reader_chk.sv
module subq_reader_chk (
    input logic clk,
    input logic rst,
    input logic rd_rise,
    input logic busy,
    input logic blk_done,
    input logic blk_ok,
    input logic q_ready,
    input logic q_sdo
);
    // R5: a failed block leaves nothing offered
    assert_fail_clears_R5: assert property (@(posedge clk) disable iff (rst)
        blk_done && !blk_ok |=> !q_ready);

    // R7: the first read edge withdraws the offer
    assert_edge_clears_R7: assert property (@(posedge clk) disable iff (rst)
        rd_rise && q_ready |=> !q_ready);

    // R7: stray read edges with nothing offered change nothing
    assert_idle_edge_R7: assert property (@(posedge clk) disable iff (rst)
        rd_rise && !q_ready && !busy && !blk_done |=> $stable(q_sdo) && !q_ready);

    // R8: serial data frozen between host edges during a read
    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        busy && !rd_rise |=> $stable(q_sdo));

    // R8: offer and read in progress never coexist
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(busy && q_ready));

    // R4: ready rises only from a passing block or a parked one after a read
    assert_ready_source_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(q_ready) |-> ($past(blk_done && blk_ok) || $past(rd_rise && busy)));

endmodule

bind subq_reader subq_reader_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_rise (rd_rise),
    .busy    (busy),
    .blk_done(blk_done),
    .blk_ok  (blk_ok),
    .q_ready (q_ready),
    .q_sdo   (q_sdo)
);

// File: tb/sim_subq_reader.sv
`timescale 1ns/1ps
module sim_subq_reader;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic       blk_sync = 1'b0;
    logic       rd_clk = 1'b0;
    logic [7:0] sym_data = '0;
    logic       q_sdo, q_ready;

    int total = 0;
    int bad   = 0;
    logic [79:0] exp_q[$];

    always #2.5 clk = ~clk;

    subq_reader u0 (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_data(sym_data),
        .blk_sync(blk_sync), .rd_clk(rd_clk), .q_sdo(q_sdo), .q_ready(q_ready)
    );

    task automatic check(string req, logic [79:0] act, logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc16(logic [79:0] d);
        logic [15:0] c = '0;
        for (int i = 0; i < 80; i++) begin
            if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    task automatic send_frame(bit sync, bit q);
        @(negedge clk);
        sym_data    = 8'($urandom);   // R2: non-Q bits random
        sym_data[6] = q;
        blk_sync    = sync;
        sym_valid   = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        blk_sync  = 1'b0;
    endtask

    // driver: sends a block and pushes the expected payload when it should be offered
    task automatic send_block(logic [79:0] d, bit corrupt, int nframes, bit push);
        logic [15:0] c;
        c = ~crc16(d);
        if (corrupt) c[3] = ~c[3];
        for (int i = 0; i < nframes; i++) begin
            if (i < 2)       send_frame(i == 0, 1'($urandom));
            else if (i < 82) send_frame(1'b0, d[i-2]);
            else             send_frame(1'b0, c[15-(i-82)]);
        end
        if (push) exp_q.push_back(d);
    endtask

    task automatic rd_edge();
        @(negedge clk); rd_clk = 1'b1;
        repeat (4) @(negedge clk);
        rd_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // monitor side: compares serial bits against the scoreboard item
    task automatic read_bits(logic [79:0] e, int from, int to);
        for (int i = from; i < to; i++) begin
            check($sformatf("R6 bit %0d", i), 80'(q_sdo), 80'(e[i]));
            rd_edge();
            if (i == 0) check("R7 ready cleared by first edge", 80'(q_ready), 80'(0));
        end
    endtask

    task automatic pop_exp(output logic [79:0] e);
        if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R4: actual=empty scoreboard expected=item");
            e = '0;
        end else e = exp_q.pop_front();
    endtask

    task automatic read_block();
        logic [79:0] e;
        pop_exp(e);
        read_bits(e, 0, 80);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [79:0] e;
        logic [79:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", 80'(q_ready), 80'(0));
        check("R1 sdo after reset", 80'(q_sdo), 80'(0));

        // R2 R3 R4 R6: good block, random non-Q bits
        send_block({$urandom, $urandom, 16'($urandom)}, 1'b0, 98, 1'b1);
        repeat (2) @(negedge clk);
        check("R4 ready after good block", 80'(q_ready), 80'(1));
        read_block();
        check("R7 ready low after full read", 80'(q_ready), 80'(0));

        // R5: failing block from idle
        send_block({$urandom, $urandom, 16'($urandom)}, 1'b1, 98, 1'b0);
        repeat (3) @(negedge clk);
        check("R5 failed block not offered", 80'(q_ready), 80'(0));

        // R5 R7: good block with bit0=1, then a failing block clears the offer
        d = {$urandom, $urandom, 16'($urandom)};
        d[0] = 1'b1;
        send_block(d, 1'b0, 98, 1'b0);
        repeat (2) @(negedge clk);
        check("R4 ready before fail", 80'(q_ready), 80'(1));
        send_block({$urandom, $urandom, 16'($urandom)}, 1'b1, 98, 1'b0);
        repeat (3) @(negedge clk);
        check("R5 fail clears ready", 80'(q_ready), 80'(0));
        check("R5 hold kept", 80'(q_sdo), 80'(1));
        rd_edge();
        check("R7 idle edge sdo unchanged", 80'(q_sdo), 80'(1));
        check("R7 idle edge ready unchanged", 80'(q_ready), 80'(0));

        // R8: a valid block arriving mid-read waits for the read to end
        send_block({$urandom, $urandom, 16'($urandom)}, 1'b0, 98, 1'b1);
        repeat (2) @(negedge clk);
        pop_exp(e);
        read_bits(e, 0, 10);
        send_block({$urandom, $urandom, 16'($urandom)}, 1'b0, 98, 1'b1);
        repeat (3) @(negedge clk);
        check("R8 hold frozen during read", 80'(q_sdo), 80'(e[10]));
        check("R8 no offer during read", 80'(q_ready), 80'(0));
        read_bits(e, 10, 80);
        check("R8 parked block offered after last edge", 80'(q_ready), 80'(1));
        read_block();

        // R9: stray strobes while idle, then an abandoned partial block
        for (int i = 0; i < 98; i++) send_frame(1'b0, 1'($urandom));
        repeat (3) @(negedge clk);
        check("R9 stray strobes ignored", 80'(q_ready), 80'(0));
        send_block({$urandom, $urandom, 16'($urandom)}, 1'b0, 40, 1'b0);
        check("R9 partial block not offered", 80'(q_ready), 80'(0));
        send_block({$urandom, $urandom, 16'($urandom)}, 1'b0, 98, 1'b1);
        repeat (2) @(negedge clk);
        check("R9 restart block offered", 80'(q_ready), 80'(1));
        read_block();   // R2 R3: payload aligned despite junk bits and restart

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule